// File: doc/BRIEF.md
# Board Interrupt Aggregator with Card-Detect Status

This block sits on a simple register bus and gathers sixteen level-sensitive interrupt lines from the board into a single interrupt request for the processor. Each line has an enable bit. While a line is enabled and high, the line sets its pending bit, and the pending bit stays set after the line drops. The processor request is raised whenever an enabled pending bit exists. Software reads the pending register to find the source. It clears a source by writing the whole pending register back with that bit at zero.

The same register space holds two socket status/control words. In each word, software may change only the low five control bits. The card-detect bit is active low and follows a dedicated interrupt line, so the status word always shows the current card presence. Eight plain 32-bit scratch registers hold LED, switch and miscellaneous control values for other board logic.

Reads are combinational from the presented address. Writes take effect on the rising clock edge. An asynchronous active-low reset is applied at once and is released in step with the clock.

Top module: `board_irq_hub`

## Requirements
- R1: After reset every register reads zero, except the two socket words, which read 0x0000_0420 (ready bit 10 and card-detect bit 5 set).
- R2: The scratch registers at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each store a full 32-bit write and return it on read.
- R3: A write to the enable register (0xC0) or the pending register (0xD0) stores only the bits set in 0x000F_EEFF, and every other bit reads zero.
- R4: At a clock edge where input line i is high and enable bit i is set, pending bit i becomes 1. A high line whose enable bit is clear leaves its pending bit unchanged.
- R5: irq_out is high exactly when the stored pending and enable registers have at least one set bit in common. It follows any write to either register from the next clock.
- R6: A write to the pending register replaces its whole contents with the masked data, so writing 0 to a bit clears it.
- R7: When a pending-register write and a latch from an enabled, high line fall on the same edge, that pending bit ends up set.
- R8: A write to socket word 0 (0xE0) or socket word 1 (0xE4) changes only bits [4:0]. All bits above bit 5 keep their value.
- R9: Bit 5 of socket word 0 reads the inverse of line 9, and bit 5 of socket word 1 reads the inverse of line 13, as sampled at the previous clock edge.
- R10: A read from any other offset returns zero, and a write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lines | input | 16 | External level interrupt inputs |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
A software write to the pending register and a hardware latch from an enabled, high line can land on the same clock edge. In that case the latch has to win, or a live source would be lost. The bench provokes this in two ways. It enables a line, then writes zero to the pending register while that line is held high. It also runs a long stretch of random writes while the lines toggle at random. A behavioural reference model, updated on every edge, gives the expected pending value, irq_out, and the read data at the current address. The bench compares these with the design at each falling edge.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_SCR = 8;

  // bits of the enable and pending registers that software can hold
  localparam logic [DATA_W-1:0] IRQ_KEEP = 32'h000F_EEFF;

  localparam logic [7:0] OFS_EN    = 8'hC0;
  localparam logic [7:0] OFS_PEND  = 8'hD0;
  localparam logic [7:0] OFS_SOCK0 = 8'hE0;
  localparam logic [7:0] OFS_SOCK1 = 8'hE4;

  localparam logic [7:0] SCR_OFS [NUM_SCR] =
    '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};

  localparam int SOCK_CTRL_W = 5;
  localparam int SOCK_CD_BIT = 5;
  localparam int SOCK_RDY_BIT = 10;
  localparam logic [DATA_W-1:0] SOCK_RST = 32'h0000_0420;
  localparam int CD_LINE0 = 9;
  localparam int CD_LINE1 = 13;
endpackage

// File: rtl/hub_rst_sync.sv
module hub_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int NUM_IRQ = 16,
  parameter int DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEEP = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               pend_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_IRQ-1:0] lines,
  output logic [DATA_W-1:0]  en_q,
  output logic [DATA_W-1:0]  pend_q,
  output logic               irq_o
);
  logic [DATA_W-1:0] lines_ext;
  logic [DATA_W-1:0] en_d;
  logic [DATA_W-1:0] pend_base;
  logic [DATA_W-1:0] pend_d;

  always_comb begin
    lines_ext = '0;
    lines_ext[NUM_IRQ-1:0] = lines;
    en_d      = wdata & KEEP;
    pend_base = pend_wr ? (wdata & KEEP) : pend_q;
    // an enabled high line overrides a same-cycle software write
    pend_d    = pend_base | (lines_ext & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq_o = |(pend_q & en_q);
endmodule

// File: rtl/sock_status_reg.sv
module sock_status_reg #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 5,
  parameter int CD_BIT = 5,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wctrl,
  input  logic              cd_line,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] d;

  always_comb begin
    d = q;
    if (wr) d[CTRL_W-1:0] = wctrl;
    d[CD_BIT] = ~cd_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end
endmodule

// File: rtl/board_irq_hub.sv
module board_irq_hub
  import board_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_lines,
  output logic               irq_out
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] sock0_q;
  logic [DATA_W-1:0] sock1_q;
  logic [DATA_W-1:0] scr_q [NUM_SCR];
  logic [NUM_SCR-1:0] scr_wr;

  logic en_wr, pend_wr, s0_wr, s1_wr;

  assign en_wr   = bus_we && (bus_addr == ADDR_W'(OFS_EN));
  assign pend_wr = bus_we && (bus_addr == ADDR_W'(OFS_PEND));
  assign s0_wr   = bus_we && (bus_addr == ADDR_W'(OFS_SOCK0));
  assign s1_wr   = bus_we && (bus_addr == ADDR_W'(OFS_SOCK1));

  hub_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  irq_pend_unit #(
    .NUM_IRQ (NUM_IRQ),
    .DATA_W  (DATA_W),
    .KEEP    (IRQ_KEEP)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_wr   (en_wr),
    .pend_wr (pend_wr),
    .wdata   (bus_wdata),
    .lines   (irq_lines),
    .en_q    (en_q),
    .pend_q  (pend_q),
    .irq_o   (irq_out)
  );

  sock_status_reg #(
    .DATA_W (DATA_W), .CTRL_W (SOCK_CTRL_W),
    .CD_BIT (SOCK_CD_BIT), .RST_VAL (SOCK_RST)
  ) u_sock0 (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (s0_wr),
    .wctrl   (bus_wdata[SOCK_CTRL_W-1:0]),
    .cd_line (irq_lines[CD_LINE0]),
    .q       (sock0_q)
  );

  sock_status_reg #(
    .DATA_W (DATA_W), .CTRL_W (SOCK_CTRL_W),
    .CD_BIT (SOCK_CD_BIT), .RST_VAL (SOCK_RST)
  ) u_sock1 (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (s1_wr),
    .wctrl   (bus_wdata[SOCK_CTRL_W-1:0]),
    .cd_line (irq_lines[CD_LINE1]),
    .q       (sock1_q)
  );

  for (genvar k = 0; k < NUM_SCR; k++) begin : g_scr
    assign scr_wr[k] = bus_we && (bus_addr == ADDR_W'(SCR_OFS[k]));

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)    scr_q[k] <= '0;
      else if (scr_wr[k]) scr_q[k] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_SCR; k++) begin
      if (bus_addr == ADDR_W'(SCR_OFS[k])) bus_rdata = scr_q[k];
    end
    if (bus_addr == ADDR_W'(OFS_EN))    bus_rdata = en_q;
    if (bus_addr == ADDR_W'(OFS_PEND))  bus_rdata = pend_q;
    if (bus_addr == ADDR_W'(OFS_SOCK0)) bus_rdata = sock0_q;
    if (bus_addr == ADDR_W'(OFS_SOCK1)) bus_rdata = sock1_q;
  end
endmodule

// File: rtl/board_irq_hub_chk.sv
module board_irq_hub_chk
  import board_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_IRQ = 16
) (
  input logic               clk,
  input logic               srst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_IRQ-1:0] irq_lines,
  input logic [DATA_W-1:0]  en_q,
  input logic [DATA_W-1:0]  pend_q,
  input logic [DATA_W-1:0]  sock0_q,
  input logic [DATA_W-1:0]  sock1_q
);
  logic [DATA_W-1:0] lines_ext;
  always_comb begin
    lines_ext = '0;
    lines_ext[NUM_IRQ-1:0] = irq_lines;
  end

  // R3
  keep_mask_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((en_q | pend_q) & ~IRQ_KEEP) == '0);

  // R4
  pend_latch_chk: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ((pend_q & $past(lines_ext & en_q)) == $past(lines_ext & en_q)));

  // R6
  pend_write_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_PEND) && (lines_ext & en_q) == '0)
    |=> pend_q == ($past(bus_wdata) & IRQ_KEEP));

  // R9
  cd0_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> sock0_q[SOCK_CD_BIT] == !$past(irq_lines[CD_LINE0]));

  // R9
  cd1_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> sock1_q[SOCK_CD_BIT] == !$past(irq_lines[CD_LINE1]));

  // R8
  sock_upper_chk: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ($stable(sock0_q[DATA_W-1:SOCK_CD_BIT+1]) &&
              $stable(sock1_q[DATA_W-1:SOCK_CD_BIT+1]) &&
              sock0_q[SOCK_RDY_BIT] && sock1_q[SOCK_RDY_BIT]));
endmodule

bind board_irq_hub board_irq_hub_chk #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .srst_n    (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .irq_lines (irq_lines),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .sock0_q   (sock0_q),
  .sock1_q   (sock1_q)
);

// File: tb/board_irq_hub_tb.sv
module board_irq_hub_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] irq_lines;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  board_irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  int unsigned scr_ofs [8] = '{'h10, 'h14, 'h40, 'h60, 'h80, 'h84, 'h88, 'h90};
  logic [31:0] m_scr [8];
  logic [31:0] m_en, m_pend, m_s0, m_s1;

  function automatic logic [31:0] model_read(input int unsigned a);
    logic [31:0] v;
    v = 32'h0;
    for (int k = 0; k < 8; k++) if (a == scr_ofs[k]) v = m_scr[k];
    if (a == 'hC0) v = m_en;
    if (a == 'hD0) v = m_pend;
    if (a == 'hE0) v = m_s0;
    if (a == 'hE4) v = m_s1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] n_en, n_pend, n_s0, n_s1;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) m_scr[k] = 32'h0;
      m_en = 0; m_pend = 0; m_s0 = 32'h420; m_s1 = 32'h420;
    end else begin
      n_en = m_en; n_pend = m_pend; n_s0 = m_s0; n_s1 = m_s1;
      if (bus_we) begin
        for (int k = 0; k < 8; k++) if (bus_addr == scr_ofs[k]) m_scr[k] = bus_wdata;
        if (bus_addr == 8'hC0) n_en = bus_wdata & 32'h000F_EEFF;
        if (bus_addr == 8'hD0) n_pend = bus_wdata & 32'h000F_EEFF;
        if (bus_addr == 8'hE0) n_s0[4:0] = bus_wdata[4:0];
        if (bus_addr == 8'hE4) n_s1[4:0] = bus_wdata[4:0];
      end
      n_pend = n_pend | ({16'h0, irq_lines} & m_en);
      n_s0[5] = ~irq_lines[9];
      n_s1[5] = ~irq_lines[13];
      m_en = n_en; m_pend = n_pend; m_s0 = n_s0; m_s1 = n_s1;
    end
  end

  task automatic check_now();
    logic [31:0] exp_rd;
    logic        exp_irq;
    exp_rd  = model_read(bus_addr);
    exp_irq = |(m_pend & m_en);
    checks++;
    if (bus_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s: rdata @%02h actual %08h expected %08h", cur_req, bus_addr, bus_rdata, exp_rd);
    end
    checks++;
    if (irq_out !== exp_irq) begin
      errors++;
      $display("FAIL %s: irq_out actual %0b expected %0b", cur_req, irq_out, exp_irq);
    end
  endtask

  // compare, then drive the next cycle's inputs
  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d,
                      input logic [15:0] ln);
    @(negedge clk);
    check_now();
    bus_addr = a; bus_we = we; bus_wdata = d; irq_lines = ln;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [15:0] ln);
    step(a, 1'b1, d, ln);
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] ln);
    step(a, 1'b0, 32'h0, ln);
  endtask

  task automatic rd_all(input logic [15:0] ln);
    for (int k = 0; k < 8; k++) rd(8'(scr_ofs[k]), ln);
    rd(8'hC0, ln); rd(8'hD0, ln); rd(8'hE0, ln); rd(8'hE4, ln);
  endtask

  initial begin
    logic [7:0] pick [14] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88,
                              8'h90, 8'hC0, 8'hD0, 8'hE0, 8'hE4, 8'h18, 8'hFC};
    rst_n = 1'b0; bus_addr = 8'hE0; bus_we = 1'b0; bus_wdata = 0; irq_lines = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    cur_req = "R1"; rd_all(16'h0);

    cur_req = "R2";
    for (int k = 0; k < 8; k++) wr(8'(scr_ofs[k]), 32'hA5A5_0000 + 32'(k * 32'h1111), 16'h0);
    rd_all(16'h0);
    for (int k = 0; k < 8; k++) wr(8'(scr_ofs[k]), ~(32'h1 << k), 16'h0);
    rd_all(16'h0);

    cur_req = "R10";
    wr(8'h18, 32'hFFFF_FFFF, 16'h0); wr(8'hFC, 32'h1234_5678, 16'h0);
    wr(8'h00, 32'hDEAD_BEEF, 16'h0); rd(8'h18, 16'h0); rd(8'h00, 16'h0);
    rd_all(16'h0);

    cur_req = "R3";
    wr(8'hC0, 32'hFFFF_FFFF, 16'h0); rd(8'hC0, 16'h0);
    wr(8'hD0, 32'hFFFF_FFFF, 16'h0); rd(8'hD0, 16'h0);

    cur_req = "R5";
    wr(8'hC0, 32'h0, 16'h0); rd(8'hD0, 16'h0); rd(8'hD0, 16'h0);
    wr(8'hC0, 32'h0001_0000, 16'h0); rd(8'hD0, 16'h0);

    cur_req = "R6";
    wr(8'hD0, 32'h0, 16'h0); rd(8'hD0, 16'h0); rd(8'hD0, 16'h0);

    cur_req = "R4";
    wr(8'hC0, 32'h0000_0008, 16'h0);
    rd(8'hD0, 16'h0010); rd(8'hD0, 16'h0); rd(8'hD0, 16'h0008);
    rd(8'hD0, 16'h0); rd(8'hD0, 16'h0);

    cur_req = "R7";
    wr(8'hD0, 32'h0, 16'h0008); rd(8'hD0, 16'h0); rd(8'hD0, 16'h0);
    wr(8'hD0, 32'h0, 16'h0); rd(8'hD0, 16'h0);

    cur_req = "R8";
    wr(8'hE0, 32'hFFFF_FFFF, 16'h0); rd(8'hE0, 16'h0);
    wr(8'hE4, 32'hFFFF_FFEA, 16'h0); rd(8'hE4, 16'h0);
    wr(8'hE0, 32'h0, 16'h0); rd(8'hE0, 16'h0);

    cur_req = "R9";
    rd(8'hE0, 16'h0200); rd(8'hE0, 16'h2000); rd(8'hE4, 16'h2000);
    rd(8'hE4, 16'h0); rd(8'hE0, 16'h0); rd(8'hE4, 16'h0);

    cur_req = "R7";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = pick[$urandom_range(13, 0)];
      step(a, 1'($urandom_range(1, 0)), $urandom, 16'($urandom));
    end
    rd_all(16'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule